// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets a clocked host read and write a wide asynchronous static RAM of 2^20 words by 32 bits, built as four 8-bit lanes. Each lane has its own active-low select, so lane choice is made by the selects themselves rather than by byte enables under one shared select. The host hands over one access at a time: a write flag, a word address, write data and a 4-bit lane mask. The controller turns it into a timed sequence of address, selects, write enable and output enable on the memory side, and it drives the shared data bus only when the memory outputs are certain to be floating.

All timing is set by parameters in clock cycles, each rounded up from the memory's nanosecond minimums at the chosen clock period: address setup before the write strobe (`T_ASU`), strobe width (`T_WE`), strobe-low time before the driver turns on (`T_FLOAT`, less than `T_WE`), data hold after the strobe (`T_HOLD`), read access wait (`T_RD`) and post-read turnaround (`T_TURN`). Every value is at least 1. A write ends with write enable and the selects rising on the same edge, and setup and hold are counted against that edge.

The request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so the host simply holds its request stable until it is taken. The response is a one-cycle `rsp_valid` pulse with no back-pressure, and the host must take `rsp_rdata` in that cycle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held, `req_ready` is 1 and `rsp_valid` is 0. All of `mem_cs_n` are 1, `mem_we_n` and `mem_oe_n` are 1, and `mem_dq_oe` is 0.
- R2: A request is taken on an edge with `req_valid` and `req_ready` both high. `req_ready` stays low from that edge until the access has completed. While `req_ready` is high, every select and both enables are high and the driver is off.
- R3: A write first presents the address for `T_ASU` cycles with all selects and write enable high. For the next `T_WE` cycles, write enable is low and `mem_cs_n[i]` is low exactly when `req_mask[i]` is 1, where lane i is data bits 8i+7..8i. Output enable stays high for the whole write, and each write strobe lasts at least `T_WE` cycles.
- R4: During a write, the data driver stays off for the first `T_FLOAT` cycles of write enable low and is on for the rest of the strobe. Write enable and the selects rise together, and the driver stays on with the same data and address for `T_HOLD` cycles after that.
- R5: A read holds write enable high. For `T_RD` cycles it holds output enable low and the masked lanes' selects low, with the address stable. It captures the bus at the end of the last of those cycles.
- R6: In the read result, each lane whose mask bit is 0 reads as zero, and each lane whose mask bit is 1 carries the captured memory byte.
- R7: `rsp_valid` is high for exactly one cycle per access. For a write it comes `T_ASU+T_WE+T_HOLD` cycles after the accepting edge. For a read it comes `T_RD` cycles after that edge, together with `rsp_rdata`.
- R8: After a read, the controller stays busy for `T_TURN` cycles with every select and both enables high and the driver off. Only then does `req_ready` rise, so a following write can never meet live memory outputs.
- R9: The data driver is never on while output enable is low.
- R10: A request with mask 0 runs its full timing with no select asserted. As a write it leaves memory unchanged, and as a read it returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 32 | Write data, lane i in bits 8i+7..8i |
| req_mask | input | 4 | Lane mask, bit i selects lane i |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result, unmasked lanes zero |
| mem_addr | output | 20 | Memory address |
| mem_cs_n | output | 4 | Per-lane active-low selects |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 32 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the bus driver |
| mem_dq_in | input | 32 | Data from the memory bus |

## Verification
Each of the 16 addresses is first filled with a full-mask write. Then, for every one of the 16 lane masks, a masked write is followed by reads under all 16 masks. This tells apart lanes that were rewritten, lanes that kept old data and lanes that must read as zero, including the all-zero mask. The bench's memory model returns a junk byte until a lane has been read-active for `T_RD` cycles. It also measures strobe width, driver setup and hold, address setup and stability, and bus contention in clock counts, so a shortened wait, an early driver or a dropped hold shows up as a data or timing mismatch. Every read is followed by a write or another read, so the turnaround after a read is exercised throughout the sweep.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RWAIT,
    ST_TURN
  } seq_state_e;

  typedef struct packed {
    logic sel;
    logic we;
    logic oe;
    logic drv;
    logic cap;
  } mem_ctl_t;

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

endpackage

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int T_ASU   = 1,
  parameter int T_WE    = 2,
  parameter int T_FLOAT = 1,
  parameter int T_HOLD  = 1,
  parameter int T_RD    = 2,
  parameter int T_TURN  = 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     start_write,
  output logic     idle,
  output mem_ctl_t ctl,
  output logic     done
);

  localparam int L_ASU  = at_least_one(T_ASU);
  localparam int L_WE   = at_least_one(T_WE);
  localparam int L_HOLD = at_least_one(T_HOLD);
  localparam int L_RD   = at_least_one(T_RD);
  localparam int L_TURN = at_least_one(T_TURN);
  localparam int L_FLT  = (T_FLOAT >= L_WE) ? L_WE - 1 : T_FLOAT;
  localparam int MAX_A  = (L_ASU > L_WE) ? L_ASU : L_WE;
  localparam int MAX_B  = (L_HOLD > L_RD) ? L_HOLD : L_RD;
  localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_L  = (MAX_C > L_TURN) ? MAX_C : L_TURN;
  localparam int CW     = $clog2(MAX_L + 1);

  seq_state_e      state_q, state_nx;
  logic [CW-1:0]   cnt_q, cnt_nx;
  logic            last;

  function automatic mem_ctl_t decode(input seq_state_e st, input logic [CW-1:0] c);
    mem_ctl_t r;
    r.sel = (st == ST_WPULSE) || (st == ST_RWAIT);
    r.we  = (st == ST_WPULSE);
    r.oe  = (st == ST_RWAIT);
    r.drv = ((st == ST_WPULSE) && (c >= CW'(L_FLT))) || (st == ST_WHOLD);
    r.cap = (st == ST_RWAIT) && (c == CW'(L_RD - 1));
    return r;
  endfunction

  always_comb begin
    case (state_q)
      ST_WSETUP: last = (cnt_q == CW'(L_ASU - 1));
      ST_WPULSE: last = (cnt_q == CW'(L_WE - 1));
      ST_WHOLD:  last = (cnt_q == CW'(L_HOLD - 1));
      ST_RWAIT:  last = (cnt_q == CW'(L_RD - 1));
      ST_TURN:   last = (cnt_q == CW'(L_TURN - 1));
      default:   last = 1'b0;
    endcase
  end

  always_comb begin
    state_nx = state_q;
    cnt_nx   = cnt_q + CW'(1);
    case (state_q)
      ST_IDLE: begin
        cnt_nx = '0;
        if (start) state_nx = start_write ? ST_WSETUP : ST_RWAIT;
      end
      ST_WSETUP: if (last) begin state_nx = ST_WPULSE; cnt_nx = '0; end
      ST_WPULSE: if (last) begin state_nx = ST_WHOLD;  cnt_nx = '0; end
      ST_WHOLD:  if (last) begin state_nx = ST_IDLE;   cnt_nx = '0; end
      ST_RWAIT:  if (last) begin state_nx = ST_TURN;   cnt_nx = '0; end
      ST_TURN:   if (last) begin state_nx = ST_IDLE;   cnt_nx = '0; end
      default: begin
        state_nx = ST_IDLE;
        cnt_nx   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ctl     <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_nx;
      cnt_q   <= cnt_nx;
      ctl     <= decode(state_nx, cnt_nx);
      done    <= last && ((state_q == ST_WHOLD) || (state_q == ST_RWAIT));
    end
  end

  assign idle = (state_q == ST_IDLE);

endmodule

// File: rtl/sram_lane_req.sv
module sram_lane_req #(
  parameter int ADDR_W = 20,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic [ADDR_W-1:0]       in_addr,
  input  logic [LANES*LANE_W-1:0] in_wdata,
  input  logic [LANES-1:0]        in_mask,
  input  logic                    sel,
  output logic [ADDR_W-1:0]       addr,
  output logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES-1:0]        mask,
  output logic [LANES-1:0]        cs_n
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      wdata <= '0;
      mask  <= '0;
    end else if (take) begin
      addr  <= in_addr;
      wdata <= in_wdata;
      mask  <= in_mask;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_sel
    assign cs_n[i] = ~(sel & mask[i]);
  end

endmodule

// File: rtl/sram_lane_rdcap.sv
module sram_lane_rdcap #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap,
  input  logic [LANES-1:0]        mask,
  input  logic [LANES*LANE_W-1:0] bus,
  output logic [LANES*LANE_W-1:0] rdata
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rdata[i*LANE_W +: LANE_W] <= '0;
      else if (cap)
        rdata[i*LANE_W +: LANE_W] <= mask[i] ? bus[i*LANE_W +: LANE_W] : '0;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter int T_ASU   = 1,
  parameter int T_WE    = 2,
  parameter int T_FLOAT = 1,
  parameter int T_HOLD  = 1,
  parameter int T_RD    = 2,
  parameter int T_TURN  = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LANES*LANE_W-1:0] req_wdata,
  input  logic [LANES-1:0]        req_mask,
  output logic                    rsp_valid,
  output logic [LANES*LANE_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [LANES-1:0]        mem_cs_n,
  output logic                    mem_we_n,
  output logic                    mem_oe_n,
  output logic [LANES*LANE_W-1:0] mem_dq_out,
  output logic                    mem_dq_oe,
  input  logic [LANES*LANE_W-1:0] mem_dq_in
);

  mem_ctl_t         ctl;
  logic             idle;
  logic             take;
  logic [LANES-1:0] mask_q;

  assign take = req_valid && idle;

  sram_lane_seq #(
    .T_ASU(T_ASU), .T_WE(T_WE), .T_FLOAT(T_FLOAT),
    .T_HOLD(T_HOLD), .T_RD(T_RD), .T_TURN(T_TURN)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(take), .start_write(req_write),
    .idle(idle), .ctl(ctl), .done(rsp_valid)
  );

  sram_lane_req #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_req (
    .clk(clk), .rst_n(rst_n), .take(take),
    .in_addr(req_addr), .in_wdata(req_wdata), .in_mask(req_mask),
    .sel(ctl.sel), .addr(mem_addr), .wdata(mem_dq_out),
    .mask(mask_q), .cs_n(mem_cs_n)
  );

  sram_lane_rdcap #(.LANES(LANES), .LANE_W(LANE_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap(ctl.cap), .mask(mask_q),
    .bus(mem_dq_in), .rdata(rsp_rdata)
  );

  assign req_ready = idle;
  assign mem_we_n  = ~ctl.we;
  assign mem_oe_n  = ~ctl.oe;
  assign mem_dq_oe = ctl.drv;

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W  = 20,
  parameter int LANES   = 4,
  parameter int T_WE    = 2,
  parameter int T_FLOAT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LANES-1:0]  mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  localparam int SAT = (T_WE > T_FLOAT) ? T_WE : T_FLOAT;
  localparam int SW  = $clog2(SAT + 1) + 1;

  logic [SW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      low_cnt <= '0;
    else if (mem_we_n)
      low_cnt <= '0;
    else if (low_cnt < SW'(SAT))
      low_cnt <= low_cnt + SW'(1);
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ((&mem_cs_n) && mem_we_n && mem_oe_n && !mem_dq_oe)); // R2
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (low_cnt >= SW'(T_WE))); // R3
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R3
  AST_FLOAT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && !mem_we_n) |-> (low_cnt >= SW'(T_FLOAT))); // R4
  AST_HOLD_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_addr) && (&mem_cs_n))); // R4
  AST_READ_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr)); // R5
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R7
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R9

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .T_WE(T_WE), .T_FLOAT(T_FLOAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;

  localparam int T_ASU = 1, T_WE = 2, T_FLOAT = 1, T_HOLD = 1, T_RD = 2, T_TURN = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_mask = '0;
  logic        req_ready, rsp_valid, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [31:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [19:0] mem_addr;
  logic [3:0]  mem_cs_n;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sram_lane_ctrl #(
    .T_ASU(T_ASU), .T_WE(T_WE), .T_FLOAT(T_FLOAT),
    .T_HOLD(T_HOLD), .T_RD(T_RD), .T_TURN(T_TURN)
  ) i_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural memory: 16 words x 4 lanes, indexed by address bits 3..0
  logic [7:0]  mem [16][4];
  logic [3:0]  cur_mask = '0;
  logic        wprev [4];
  int          wlen [4], slen [4], rage [4];
  logic [7:0]  wdat [4];
  logic [19:0] waddr [4];
  logic [19:0] last_addr = '0;
  int          addr_age = 0, we_age = 0;

  function automatic logic [19:0] mk_addr(input logic [3:0] a);
    return {a, 12'hA5C, a};
  endfunction

  always_comb begin
    for (int i = 0; i < 4; i++)
      mem_dq_in[i*8 +: 8] = (!mem_cs_n[i] && mem_we_n && !mem_oe_n && rage[i] >= T_RD)
                            ? mem[mem_addr[3:0]][i] : 8'h5A;
  end

  initial begin
    for (int a = 0; a < 16; a++)
      for (int i = 0; i < 4; i++) mem[a][i] = 8'h00;
    for (int i = 0; i < 4; i++) begin
      wprev[i] = 1'b0; wlen[i] = 0; slen[i] = 0; rage[i] = 0; wdat[i] = '0; waddr[i] = '0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_we_n) chk(mem_cs_n == ~cur_mask && mem_oe_n, "R3 strobe selects", {27'd0, mem_oe_n, mem_cs_n}, {27'd1, ~cur_mask});
      if (!mem_oe_n) begin
        chk(mem_cs_n == ~cur_mask && mem_we_n, "R5 read selects", {27'd0, mem_we_n, mem_cs_n}, {27'd1, ~cur_mask});
        chk(mem_addr[19:16] == mem_addr[3:0] && mem_addr[15:4] == 12'hA5C, "R5 address", {12'd0, mem_addr}, {12'd0, mk_addr(mem_addr[3:0])});
      end
      if (mem_dq_oe) chk(mem_oe_n, "R9 contention", {31'd0, mem_oe_n}, 32'd1);
      if (mem_dq_oe && !mem_we_n) chk(we_age >= T_FLOAT, "R4 float wait", we_age, T_FLOAT);
      for (int i = 0; i < 4; i++) begin
        if (!mem_cs_n[i] && !mem_we_n) begin
          if (!wprev[i]) begin
            chk(addr_age >= T_ASU || mem_addr == last_addr, "R3 address setup", addr_age, T_ASU);
            chk(mem_addr[19:16] == mem_addr[3:0] && mem_addr[15:4] == 12'hA5C, "R3 address", {12'd0, mem_addr}, {12'd0, mk_addr(mem_addr[3:0])});
            wlen[i] = 0; slen[i] = 0; waddr[i] = mem_addr;
          end
          chk(mem_addr == waddr[i], "R3 address stable", {12'd0, mem_addr}, {12'd0, waddr[i]});
          wlen[i]++;
          if (mem_dq_oe) begin
            if (slen[i] > 0 && mem_dq_out[i*8 +: 8] != wdat[i]) slen[i] = 1;
            else slen[i]++;
            wdat[i] = mem_dq_out[i*8 +: 8];
          end else slen[i] = 0;
          wprev[i] = 1'b1;
        end else if (wprev[i]) begin
          chk(wlen[i] >= T_WE, "R3 strobe width", wlen[i], T_WE);
          chk(slen[i] >= T_WE - T_FLOAT, "R4 data setup", slen[i], T_WE - T_FLOAT);
          chk(mem_dq_oe && mem_dq_out[i*8 +: 8] == wdat[i] && mem_addr == waddr[i], "R4 data hold",
              {23'd0, mem_dq_oe, mem_dq_out[i*8 +: 8]}, {23'd1, wdat[i]});
          mem[waddr[i][3:0]][i] = wdat[i];
          wprev[i] = 1'b0;
        end
        if (!mem_cs_n[i] && mem_we_n && !mem_oe_n) rage[i]++;
        else rage[i] = 0;
      end
      if (mem_addr == last_addr) addr_age++;
      else addr_age = 0;
      last_addr = mem_addr;
      if (!mem_we_n) we_age++;
      else we_age = 0;
    end
  end

  task automatic access(input bit wr, input logic [3:0] a, input logic [31:0] d,
                        input logic [3:0] m, output logic [31:0] rd);
    int k;
    int exp_k;
    @(negedge clk);
    cur_mask  = m;
    req_valid = 1'b1; req_write = wr; req_addr = mk_addr(a); req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = 1;
    chk(!req_ready, "R2 busy after accept", {31'd0, req_ready}, 32'd0);
    while (!rsp_valid && k < 50) begin @(negedge clk); k++; end
    exp_k = wr ? (T_ASU + T_WE + T_HOLD + 1) : (T_RD + 1);
    chk(k == exp_k, "R7 done latency", k, exp_k);
    rd = rsp_rdata;
    chk(req_ready == wr, "R8 ready at done", {31'd0, req_ready}, {31'd0, wr});
    if (!wr) chk((&mem_cs_n) && mem_we_n && mem_oe_n && !mem_dq_oe, "R8 turnaround quiet",
                 {25'd0, mem_dq_oe, mem_oe_n, mem_we_n, mem_cs_n}, {25'd0, 3'b011, 4'hF});
    @(negedge clk);
    chk(!rsp_valid, "R7 single pulse", {31'd0, rsp_valid}, 32'd0);
    if (!wr) begin
      repeat (T_TURN - 1) @(negedge clk);
      chk(req_ready, "R8 ready after turnaround", {31'd0, req_ready}, 32'd1);
    end
  endtask

  function automatic logic [31:0] init_word(input int a);
    return 32'h1357_9BDF * (a + 1) ^ 32'h8040_2010;
  endfunction

  function automatic logic [31:0] new_word(input int m);
    return 32'h0123_4567 * (m + 3) ^ 32'hA5A5_0F0F;
  endfunction

  logic [31:0] sb [16];

  initial begin
    logic [31:0] rd, exp;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && (&mem_cs_n) && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 reset state",
        {25'd0, req_ready, rsp_valid, mem_dq_oe, mem_cs_n}, {25'd0, 3'b100, 4'hF});
    rst_n = 1'b1;

    for (int a = 0; a < 16; a++) begin
      access(1'b1, 4'(a), init_word(a), 4'hF, rd);
      sb[a] = init_word(a);
    end
    for (int a = 0; a < 16; a++) begin
      access(1'b0, 4'(a), 32'h0, 4'hF, rd);
      chk(rd == sb[a], "R5 full readback", rd, sb[a]);
    end

    for (int m = 0; m < 16; m++) begin
      access(1'b1, 4'(m), new_word(m), 4'(m), rd);
      for (int i = 0; i < 4; i++)
        if (m[i]) sb[m][i*8 +: 8] = new_word(m) >> (i*8);
      for (int r = 0; r < 16; r++) begin
        access(1'b0, 4'(m), 32'h0, 4'(r), rd);
        for (int i = 0; i < 4; i++)
          exp[i*8 +: 8] = r[i] ? sb[m][i*8 +: 8] : 8'h00;
        if (r == 0 || m == 0) chk(rd == exp, "R10 zero mask", rd, exp);
        else chk(rd == exp, "R6 masked readback", rd, exp);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule